// File: doc/BRIEF.md
# Mains-Locked S-FSK Transmitter

This block turns a serial stream of data bits into digital carrier samples for a power-line link. Each bit is sent as one of two tones that are placed far apart in frequency: a zero uses the space tone and a one uses the mark tone. The tones come from a 32-bit phase accumulator. Each tone has its own increment input. When the bit changes, only the increment is switched, so the carrier phase stays continuous. The top phase bits address a quarter-wave sine table, which gives 12-bit signed samples at one sample per clock.

Bit timing follows the mains rather than a fixed baud divider. A zero-crossing strobe marks each half-cycle boundary. The block counts clocks between strobes and divides each half-cycle into 3, 6, 12 or 24 equal slots. It re-measures the half-cycle every time, so the bit rate tracks the mains frequency, whether 50 Hz or 60 Hz. Transmission is half duplex. Once transmit-enable is high, the first slot starts at the next zero crossing. One bit is taken from a ready/valid input at each slot boundary. If no bit is waiting, the block flags an underrun and sends the space tone for that slot.

Top module: `sfsk_tx`

## Requirements
- R1: A bit of 0 is sent with `space_inc_i` and a bit of 1 with `mark_inc_i`. `sample_mark_o` is 1 for mark and 0 for space, and it holds one value for every sample of a slot.
- R2: The phase is 0 for the first sample of a transmission. Each later sample has the previous phase plus the increment of the previous sample's tone, modulo 2^32. The phase is never reset at slot boundaries.
- R3: Every valid sample is within 8 LSB of 2047·sin(2π·phase/2^32) and never exceeds ±2047 in magnitude.
- R4: The slot length is floor(H / N) clocks. H is the number of clocks between the two most recent zero-crossing strobes. N is 3, 6, 12 or 24 for `dens_i` = 0, 1, 2 or 3. The length is re-measured at every strobe.
- R5: A half-cycle holds at most N slots. Every strobe starts a new slot, so the last slot of a half-cycle stretches to the next strobe: H − (N−1)·floor(H/N) clocks.
- R6: A transmission starts at the first strobe sampled while `tx_en_i` is high. Its first valid sample appears three rising edges after the edge that first samples that strobe high, and `slot_start_o` is high on that sample.
- R7: `in_ready_o` is high for exactly one cycle at each slot boundary while transmitting, and the bit is accepted in that cycle.
- R8: If `in_valid_i` is low at a slot boundary, `underrun_o` rises together with `slot_start_o`, and that slot is sent with the space tone.
- R9: While `tx_en_i` is low, `in_ready_o` stays low. `sample_valid_o` falls within three cycles, and `sample_o` is 0 whenever it is not valid.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_i | input | 1 | One-cycle strobe at each mains zero crossing |
| tx_en_i | input | 1 | Transmit enable (half-duplex turn) |
| dens_i | input | 2 | Bits per half-cycle: 0→3, 1→6, 2→12, 3→24 |
| mark_inc_i | input | 32 | Phase increment of the mark tone (bit 1) |
| space_inc_i | input | 32 | Phase increment of the space tone (bit 0) |
| in_valid_i | input | 1 | A data bit is offered |
| in_bit_i | input | 1 | Offered data bit |
| in_ready_o | output | 1 | Bit accepted in this cycle (slot boundary) |
| sample_o | output | 12 | Signed carrier sample |
| sample_valid_o | output | 1 | `sample_o` carries a transmitted sample |
| sample_mark_o | output | 1 | Tone of this sample: 1 mark, 0 space |
| slot_start_o | output | 1 | First sample of a bit slot |
| underrun_o | output | 1 | This slot had no bit waiting |

## Verification
The bench follows a reference phase through every sample, including those at bit changes. A design that resets or jumps its phase at a slot boundary, or that swaps the two increments, soon drifts away from the ideal sine. It measures the spacing of slot starts at several densities and with a half-cycle that N does not divide. A design that lets a rounding remainder become an extra short slot, or that forgets to re-align on a strobe, shows a wrong gap. It also checks the start latency against the strobe, and it stops feeding bits to force underruns, which must produce the space tone and no stale bit.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;

  // Per-slot tag carried alongside the sample pipeline
  typedef struct packed {
    logic start;     // first sample of a slot
    logic underrun;  // slot had no bit waiting
    logic mark;      // tone in use: 1 mark, 0 space
  } slot_tag_t;

  localparam int unsigned DENS_W = 2;
  localparam int unsigned SLOT_IDX_W = 6;

  // Slots per half-cycle for a density code: 3 << code
  function automatic logic [SLOT_IDX_W-1:0] slots_per_half(input logic [DENS_W-1:0] code);
    return SLOT_IDX_W'(3) << code;
  endfunction

endpackage

// File: rtl/sfsk_slot_timer.sv
module sfsk_slot_timer
  import sfsk_pkg::*;
#(
  parameter int unsigned HC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zc_i,
  input  logic              tx_en_i,
  input  logic [DENS_W-1:0] dens_i,
  output logic              edge_o,
  output logic              active_o
);

  localparam logic [HC_W-1:0] HC_MAX = '1;

  logic                  zc_q;
  logic [HC_W-1:0]       hc_cnt;
  logic [HC_W-1:0]       slot_len;
  logic [HC_W-1:0]       slot_cnt;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [HC_W-1:0]       meas;
  logic [HC_W-1:0]       len_next;
  logic [SLOT_IDX_W-1:0] slots;
  logic                  cnt_done;

  assign meas     = (hc_cnt == HC_MAX) ? HC_MAX : hc_cnt + HC_W'(1);
  assign len_next = (meas / HC_W'(3)) >> dens_i;
  assign slots    = slots_per_half(dens_i);

  // Counted boundary only while slots remain in this half-cycle
  assign cnt_done = active_o && (slot_len != '0) &&
                    (slot_cnt == slot_len - HC_W'(1)) && (slot_idx < slots);

  // Every strobe re-aligns; a strobe while idle-but-enabled starts sending
  assign edge_o = tx_en_i && (zc_q || cnt_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      zc_q     <= 1'b0;
      hc_cnt   <= '0;
      slot_len <= '0;
      slot_cnt <= '0;
      slot_idx <= '0;
      active_o <= 1'b0;
    end else begin
      zc_q <= zc_i;

      if (zc_q) begin
        hc_cnt   <= '0;
        slot_len <= len_next;
      end else if (hc_cnt != HC_MAX) begin
        hc_cnt <= hc_cnt + HC_W'(1);
      end

      active_o <= tx_en_i && (active_o || edge_o);

      if (edge_o) begin
        slot_cnt <= '0;
        slot_idx <= zc_q ? SLOT_IDX_W'(1) : slot_idx + SLOT_IDX_W'(1);
      end else if (slot_cnt != HC_MAX) begin
        slot_cnt <= slot_cnt + HC_W'(1);
      end
    end
  end

endmodule

// File: rtl/sfsk_bit_sel.sv
module sfsk_bit_sel
  import sfsk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      edge_i,
  input  logic      in_valid_i,
  input  logic      in_bit_i,
  output logic      in_ready_o,
  output slot_tag_t tag_o
);

  assign in_ready_o = edge_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_o <= '0;
    end else begin
      tag_o.start    <= edge_i;
      tag_o.underrun <= edge_i & ~in_valid_i;
      if (edge_i) begin
        // Starved slot falls back to the space tone
        tag_o.mark <= in_valid_i & in_bit_i;
      end
    end
  end

endmodule

// File: rtl/sfsk_nco.sv
module sfsk_nco
  import sfsk_pkg::*;
#(
  parameter int unsigned PHASE_W   = 32,
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned LUT_ABITS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       run_i,
  input  slot_tag_t                  tag_i,
  input  logic [PHASE_W-1:0]         mark_inc_i,
  input  logic [PHASE_W-1:0]         space_inc_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o,
  output slot_tag_t                  tag_o
);

  localparam int unsigned AMP_W = SAMPLE_W - 1;
  localparam int unsigned LUT_N = 1 << LUT_ABITS;
  localparam real         AMP_R = real'((1 << AMP_W) - 1);
  localparam real         QPI   = 1.5707963267948966;

  logic [PHASE_W-1:0]   phase;
  logic [1:0]           quad;
  logic [LUT_ABITS-1:0] idx;
  logic [LUT_ABITS-1:0] addr;
  logic [AMP_W-1:0]     rom [LUT_N];
  logic [AMP_W-1:0]     mag_q;
  logic                 neg_q;
  logic                 run_q;
  slot_tag_t            tag_q;
  logic signed [SAMPLE_W-1:0] mag_s;

  // Quarter-wave table sampled at bin midpoints, so mirroring is exact
  initial begin
    for (int i = 0; i < LUT_N; i++) begin
      rom[i] = AMP_W'($rtoi(AMP_R * $sin(QPI * (real'(i) + 0.5) / real'(LUT_N)) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (start_i) begin
      phase <= '0;
    end else if (run_i) begin
      phase <= phase + (tag_i.mark ? mark_inc_i : space_inc_i);
    end
  end

  assign quad = phase[PHASE_W-1 -: 2];
  assign idx  = phase[PHASE_W-3 -: LUT_ABITS];
  assign addr = quad[0] ? ~idx : idx;

  // Registered read without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    mag_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
      run_q <= 1'b0;
      tag_q <= '0;
    end else begin
      neg_q <= quad[1];
      run_q <= run_i;
      tag_q <= tag_i;
    end
  end

  assign mag_s = $signed({1'b0, mag_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
      tag_o    <= '0;
    end else begin
      valid_o  <= run_q;
      sample_o <= run_q ? (neg_q ? -mag_s : mag_s) : '0;
      tag_o    <= run_q ? tag_q : '0;
    end
  end

endmodule

// File: rtl/sfsk_tx.sv
module sfsk_tx
  import sfsk_pkg::*;
#(
  parameter int unsigned PHASE_W   = 32,
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned LUT_ABITS = 8,
  parameter int unsigned HC_W      = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       zc_i,
  input  logic                       tx_en_i,
  input  logic [1:0]                 dens_i,
  input  logic [PHASE_W-1:0]         mark_inc_i,
  input  logic [PHASE_W-1:0]         space_inc_i,
  input  logic                       in_valid_i,
  input  logic                       in_bit_i,
  output logic                       in_ready_o,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_valid_o,
  output logic                       sample_mark_o,
  output logic                       slot_start_o,
  output logic                       underrun_o
);

  logic      slot_edge;
  logic      active;
  slot_tag_t cur_tag;
  slot_tag_t out_tag;

  sfsk_slot_timer #(.HC_W(HC_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .zc_i     (zc_i),
    .tx_en_i  (tx_en_i),
    .dens_i   (dens_i),
    .edge_o   (slot_edge),
    .active_o (active)
  );

  sfsk_bit_sel u_bits (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (slot_edge),
    .in_valid_i (in_valid_i),
    .in_bit_i   (in_bit_i),
    .in_ready_o (in_ready_o),
    .tag_o      (cur_tag)
  );

  sfsk_nco #(
    .PHASE_W   (PHASE_W),
    .SAMPLE_W  (SAMPLE_W),
    .LUT_ABITS (LUT_ABITS)
  ) u_nco (
    .clk         (clk),
    .rst         (rst),
    .start_i     (slot_edge & ~active),
    .run_i       (active),
    .tag_i       (cur_tag),
    .mark_inc_i  (mark_inc_i),
    .space_inc_i (space_inc_i),
    .sample_o    (sample_o),
    .valid_o     (sample_valid_o),
    .tag_o       (out_tag)
  );

  assign sample_mark_o = out_tag.mark;
  assign slot_start_o  = out_tag.start;
  assign underrun_o    = out_tag.underrun;

endmodule

// File: rtl/sfsk_tx_chk.sv
module sfsk_tx_chk #(
  parameter int unsigned SAMPLE_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tx_en_i,
  input logic                       in_ready_o,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic                       sample_valid_o,
  input logic                       sample_mark_o,
  input logic                       slot_start_o,
  input logic                       underrun_o
);

  localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;

  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> tx_en_i); // R7

  AST_UNDERRUN_IS_SPACE: assert property (@(posedge clk) disable iff (rst)
    underrun_o |-> (slot_start_o && !sample_mark_o)); // R8

  AST_TONE_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_o && !slot_start_o && $past(sample_valid_o)) |-> $stable(sample_mark_o)); // R1

  AST_SAMPLE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> ((int'(sample_o) <= AMP) && (int'(sample_o) >= -AMP))); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sample_valid_o |-> (sample_o == '0) && !slot_start_o && !underrun_o); // R9

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_i && $past(!tx_en_i) && $past(!tx_en_i, 2)) |=> !sample_valid_o); // R9

endmodule

bind sfsk_tx sfsk_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_en_i        (tx_en_i),
  .in_ready_o     (in_ready_o),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .sample_mark_o  (sample_mark_o),
  .slot_start_o   (slot_start_o),
  .underrun_o     (underrun_o)
);

// File: tb/sfsk_tx_tb.sv
`timescale 1ns/1ps
module sfsk_tx_tb;

  localparam int CLK_PERIOD = 20;
  localparam logic [31:0] SPACE_INC = 32'h0147_AE14;
  localparam logic [31:0] MARK_INC  = 32'h0366_6666;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        zc = 1'b0;
  logic        tx_en = 1'b0;
  logic [1:0]  dens = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_ready;
  logic signed [11:0] sample;
  logic        s_valid, s_mark, s_start, s_under;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  longint      cyc = 0;
  longint      zc_cyc = 0;
  int          half_len = 240;
  int          exp_len = 80;
  int          exp_last = 80;
  int          n_under = 0;
  bit          exp_q[$];

  sfsk_tx u_dut (
    .clk (clk), .rst (rst), .zc_i (zc), .tx_en_i (tx_en), .dens_i (dens),
    .mark_inc_i (MARK_INC), .space_inc_i (SPACE_INC),
    .in_valid_i (in_valid), .in_bit_i (in_bit), .in_ready_o (in_ready),
    .sample_o (sample), .sample_valid_o (s_valid), .sample_mark_o (s_mark),
    .slot_start_o (s_start), .underrun_o (s_under)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Mains zero-crossing strobe generator
  initial begin
    forever begin
      repeat (half_len - 1) @(negedge clk);
      zc = 1'b1;
      zc_cyc = cyc;
      @(negedge clk);
      zc = 1'b0;
    end
  end

  // Monitor / scoreboard
  logic [31:0] model_ph = '0;
  bit          prev_valid = 1'b0;
  bit          cur_mark = 1'b0;
  longint      last_start = -1;

  always @(negedge clk) begin
    if (!rst) begin
      if (s_valid) begin
        if (!prev_valid) begin
          model_ph = '0;
          last_start = -1;
          check(cyc - zc_cyc == 4, "R6 latency", cyc - zc_cyc, 4);
          check(s_start, "R6 first slot", s_start, 1);
        end
        begin
          real ideal;
          int  ideal_i, diff;
          ideal = 2047.0 * $sin(6.283185307179586 * real'(model_ph) / 4294967296.0);
          ideal_i = $rtoi(ideal + ((ideal < 0.0) ? -0.5 : 0.5));
          diff = int'(sample) - ideal_i;
          check(diff <= 8 && diff >= -8, "R2 R3 sample", sample, ideal_i);
        end
        if (s_start) begin
          if (last_start >= 0)
            check((cyc - last_start == exp_len) || (cyc - last_start == exp_last),
                  "R4 R5 slot gap", cyc - last_start, exp_len);
          last_start = cyc;
          if (s_under) begin
            n_under++;
            check(exp_q.size() == 0, "R8 underrun with bit queued", exp_q.size(), 0);
            check(!s_mark, "R8 underrun tone", s_mark, 0);
          end else if (exp_q.size() == 0) begin
            check(1'b0, "R7 slot without accepted bit", 0, 1);
          end else begin
            bit e;
            e = exp_q.pop_front();
            check(s_mark == e, "R1 tone", s_mark, e);
          end
          cur_mark = s_mark;
        end else begin
          check(s_mark == cur_mark, "R1 tone held", s_mark, cur_mark);
        end
        model_ph = model_ph + (s_mark ? MARK_INC : SPACE_INC);
      end else begin
        check(sample == 0, "R9 idle sample", sample, 0);
      end
      prev_valid = s_valid;
    end
  end

  task automatic send_bit(input bit b);
    in_valid = 1'b1;
    in_bit = b;
    do @(negedge clk); while (!in_ready);
    exp_q.push_back(b);
    @(negedge clk);
    check(!in_ready, "R7 ready one cycle", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input int h, input logic [1:0] d, input logic [15:0] pat, input int n);
    int slots;
    slots = 3 << d;
    half_len = h;
    dens = d;
    exp_len = h / slots;
    exp_last = h - (slots - 1) * exp_len;
    repeat (4 * h) @(negedge clk);
    tx_en = 1'b1;
    for (int i = 0; i < n; i++) send_bit(pat[i]);
    repeat (2 * exp_len + 10) @(negedge clk);
    tx_en = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R7 all bits sent", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!in_ready && !s_valid && sample == 0 && !s_start && !s_under && !s_mark,
          "R10 reset outputs", {in_ready, s_valid, s_start, s_under, s_mark}, 0);
    rst = 1'b0;

    run_case(240, 2'd0, 16'b0000_0000_0011_0101, 6);   // 3 slots of 80
    run_case(240, 2'd3, 16'b0000_1010_0110_1101, 12);  // 24 slots of 10
    run_case(250, 2'd0, 16'b0000_0000_0010_1110, 6);   // 83, 83, then 84
    run_case(240, 2'd1, 16'b0000_0000_1100_1001, 8);   // 6 slots of 40

    check(n_under > 0, "R8 underrun seen", n_under, 1);

    begin
      bit seen;
      seen = 1'b0;
      in_valid = 1'b1;
      in_bit = 1'b1;
      repeat (3 * 240) begin
        @(negedge clk);
        if (in_ready || s_valid) seen = 1'b1;
      end
      in_valid = 1'b0;
      check(!seen, "R9 disabled stays quiet", seen, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule